// File: doc/BRIEF.md
# Branch Target Cache

This block predicts where instruction fetch goes next. The fetch stage presents its current program counter on the lookup port in every cycle. The block answers in the same cycle from its registered storage. When the full PC matches a stored branch, the answer is the remembered target. Otherwise the answer is the sequential address, PC plus the instruction size.

Only branches that were last seen taken are held. When a branch resolves later in the pipeline, it reports its PC, its outcome and its actual target on the update port:
- A taken outcome writes or overwrites the entry.
- A not-taken outcome for a branch that is currently stored removes that entry.

The organisation is direct-mapped: the index is taken from the PC bits just above the instruction-size offset. The full PC is kept as the tag, because at fetch time the instruction has not been decoded and a partial match could redirect a non-branch.

Top module: `btb_top`

## Requirements
- R1: A synchronous active-high reset invalidates every entry; in the cycles after reset every lookup misses (lookupHit = 0, lookupNextPc = lookupPc + 4).
- R2: A lookup that misses returns lookupHit = 0 and lookupNextPc = lookupPc + 4.
- R3: A hit requires the full 32-bit stored PC to equal lookupPc; a PC with the same index bits PC[7:2] but different upper bits misses.
- R4: A lookup that hits returns lookupHit = 1 and lookupNextPc equal to the stored target.
- R5: An update with updValid = 1 and updTaken = 1 writes or overwrites the entry at index updPc[7:2] with updPc and updTarget; a lookup of that PC hits with that target from the next cycle on.
- R6: An update with updValid = 1 and updTaken = 0 whose updPc equals the valid stored PC at its index invalidates that entry.
- R7: A not-taken update whose updPc is not the PC stored at its index leaves that entry unchanged.
- R8: When a lookup and an update address the same index in one cycle, the lookup returns the contents from before the update; the new contents are seen the following cycle.
- R9: The buffer has 64 direct-mapped entries indexed by PC[7:2]. Branches with different index bits coexist, including index 63. A taken branch evicts a different PC that is held at the same index.
- R10: While updValid = 0, updPc, updTaken and updTarget have no effect on the stored entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all valid bits |
| lookupPc | input | 32 | Current fetch PC |
| lookupHit | output | 1 | Stored taken branch matches lookupPc |
| lookupNextPc | output | 32 | Predicted next fetch PC |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | 32 | PC of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| updTarget | input | 32 | Actual target of the resolved branch |

## Verification
The lookup and a resolution update can fall in the same cycle and at the same index. This happens whenever fetch reaches a branch while an earlier instance of that branch is resolving. The bench provokes the case by holding lookupPc on a stored branch while it drives a taken update with a new target at that PC. It samples before the clock edge and expects the old target. It then samples again after the edge and expects the new target.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int PC_W        = 32;
  localparam int ENTRIES     = 64;
  localparam int INSTR_BYTES = 4;
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int IDX_LO      = $clog2(INSTR_BYTES);

  typedef struct packed {
    logic             wrEn;   // allocate / overwrite entry
    logic             clrEn;  // drop entry
    logic [IDX_W-1:0] idx;    // entry addressed by the update
  } btbStrobe_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int PcW = PC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           updValid,
  input  logic [PcW-1:0] updPc,
  input  logic           updTaken,
  input  logic           updEntryMatch,
  output btbStrobe_t     strobe
);
  always_comb begin
    strobe.idx   = updPc[IDX_LO +: IDX_W];
    strobe.wrEn  = updValid && updTaken;
    strobe.clrEn = updValid && !updTaken && updEntryMatch;
  end

  // R7: a not-taken report for a foreign PC must not produce a clear
  p_no_foreign_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updTaken && !updEntryMatch) |-> !strobe.clrEn);
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PcW     = PC_W,
  parameter int Entries = ENTRIES,
  parameter int Step    = INSTR_BYTES
) (
  input  logic           clk,
  input  logic           rst,
  input  btbStrobe_t     strobe,
  input  logic [PcW-1:0] updPc,
  input  logic [PcW-1:0] updTarget,
  output logic           updEntryMatch,
  input  logic [PcW-1:0] lookupPc,
  output logic           lookupHit,
  output logic [PcW-1:0] lookupNextPc
);
  logic [Entries-1:0] validQ;
  logic [PcW-1:0]     tagQ [Entries];
  logic [PcW-1:0]     tgtQ [Entries];
  logic [IDX_W-1:0]   lookIdx;
  logic [IDX_W-1:0]   updIdx;

  assign lookIdx = lookupPc[IDX_LO +: IDX_W];
  assign updIdx  = updPc[IDX_LO +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (strobe.wrEn) begin
      validQ[strobe.idx] <= 1'b1;
    end else if (strobe.clrEn) begin
      validQ[strobe.idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagQ[strobe.idx] <= updPc;
      tgtQ[strobe.idx] <= updTarget;
    end
  end

  always_comb begin
    updEntryMatch = validQ[updIdx] && (tagQ[updIdx] == updPc);
    lookupHit     = validQ[lookIdx] && (tagQ[lookIdx] == lookupPc);
    lookupNextPc  = lookupHit ? tgtQ[lookIdx] : lookupPc + PcW'(Step);
  end

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (validQ == '0));
  p_write_sets_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> validQ[$past(strobe.idx)]);
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.clrEn |=> !validQ[$past(strobe.idx)]);
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !(strobe.wrEn || strobe.clrEn) |=> $stable(validQ));
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookupPc,
  output logic            lookupHit,
  output logic [PC_W-1:0] lookupNextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget
);
  btbStrobe_t strobe;
  logic       updEntryMatch;

  btb_ctrl #(.PcW(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updEntryMatch(updEntryMatch), .strobe(strobe)
  );

  btb_store #(.PcW(PC_W), .Entries(ENTRIES), .Step(INSTR_BYTES)) u_store (
    .clk(clk), .rst(rst), .strobe(strobe), .updPc(updPc),
    .updTarget(updTarget), .updEntryMatch(updEntryMatch),
    .lookupPc(lookupPc), .lookupHit(lookupHit), .lookupNextPc(lookupNextPc)
  );
endmodule

// File: tb/btb_top_tb.sv
module btb_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lookupPc = '0;
  logic        lookupHit;
  logic [31:0] lookupNextPc;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [31:0] PC_A     = 32'h0000_1010; // index 4
  localparam logic [31:0] PC_ALIAS = 32'h0000_2010; // index 4
  localparam logic [31:0] PC_B     = 32'h0000_1014; // index 5
  localparam logic [31:0] PC_TOP   = 32'h0000_00FC; // index 63

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_top u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive lookupPc away from the edge and check both outputs
  task automatic look(string req, logic [31:0] pc, logic expHit, logic [31:0] expNext);
    @(negedge clk);
    lookupPc = pc;
    #1;
    check(req, {31'd0, lookupHit}, {31'd0, expHit});
    check(req, lookupNextPc, expNext);
  endtask

  task automatic resolve(logic [31:0] pc, logic taken, logic [31:0] tgt, logic vld);
    @(negedge clk);
    updValid = vld; updPc = pc; updTaken = taken; updTarget = tgt;
    @(posedge clk);
    @(negedge clk);
    updValid = 1'b0; updTaken = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    look("R1", PC_A, 1'b0, PC_A + 4);
    look("R1", PC_B, 1'b0, PC_B + 4);
  endtask

  task automatic t_alloc();
    look("R2", PC_A, 1'b0, PC_A + 4);
    resolve(PC_A, 1'b1, 32'h0000_4000, 1'b1);
    look("R5", PC_A, 1'b1, 32'h0000_4000);
    look("R4", PC_A, 1'b1, 32'h0000_4000);
    look("R3", PC_ALIAS, 1'b0, PC_ALIAS + 4);
  endtask

  task automatic t_ignored();
    resolve(PC_B, 1'b1, 32'h0000_9999, 1'b0);
    look("R10", PC_B, 1'b0, PC_B + 4);
    resolve(PC_A, 1'b0, 32'h0, 1'b0);
    look("R10", PC_A, 1'b1, 32'h0000_4000);
  endtask

  task automatic t_mapping();
    resolve(PC_B, 1'b1, 32'h0000_5000, 1'b1);
    look("R9", PC_A, 1'b1, 32'h0000_4000);
    look("R9", PC_B, 1'b1, 32'h0000_5000);
    resolve(PC_TOP, 1'b1, 32'h0000_0100, 1'b1);
    look("R9", PC_TOP, 1'b1, 32'h0000_0100);
    look("R9", 32'h0, 1'b0, 32'h4);
    resolve(PC_ALIAS, 1'b1, 32'h0000_6000, 1'b1);
    look("R9", PC_ALIAS, 1'b1, 32'h0000_6000);
    look("R9", PC_A, 1'b0, PC_A + 4);
  endtask

  task automatic t_not_taken();
    resolve(PC_A, 1'b0, 32'h0, 1'b1);
    look("R7", PC_ALIAS, 1'b1, 32'h0000_6000);
    resolve(PC_ALIAS, 1'b0, 32'h0, 1'b1);
    look("R6", PC_ALIAS, 1'b0, PC_ALIAS + 4);
    look("R6", PC_B, 1'b1, 32'h0000_5000);
  endtask

  task automatic t_same_cycle();
    resolve(PC_B, 1'b1, 32'h0000_5500, 1'b1);
    look("R5", PC_B, 1'b1, 32'h0000_5500);
    @(negedge clk);
    lookupPc = PC_B;
    updValid = 1'b1; updPc = PC_B; updTaken = 1'b1; updTarget = 32'h0000_7000;
    #1;
    check("R8", lookupNextPc, 32'h0000_5500);
    @(posedge clk);
    @(negedge clk);
    updValid = 1'b0; updTaken = 1'b0;
    #1;
    check("R8", lookupNextPc, 32'h0000_7000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alloc();
    t_ignored();
    t_mapping();
    t_not_taken();
    t_same_cycle();
    t_reset();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule